// File: doc/BRIEF.md
# Program Counter Fetch Sequencer

This block holds the program counter of a small two-stage-pipelined microcontroller and decides which program word is fetched next. Each instruction cycle lasts four clocks, marked by a rotating one-hot phase vector. During one instruction cycle the word addressed by the counter is read from a synchronous program memory while the word fetched in the previous cycle is handed to the execute stage. At the clock edge that closes phase T4 the block picks the next counter value and moves the fetched word into the execute register. That value comes from reset, an interrupt vector, a jump/call/return target, a write to the memory-mapped low counter byte, a taken skip, or a plain increment.

Whenever the flow of control changes, the word already fetched is thrown away. The following instruction cycle is then a dummy: `ex_nop` is raised, and the execute stage must suppress every register and memory write. The low eight counter bits are visible on the data bus at address 0x06. Writing them there performs a jump inside the current 256-word page.

Top module: `pc_fetch_seq`

## Requirements
- R1: `phase` is one-hot. It reads 4'b0001 (T1) while reset is active and then advances T1→T2→T3→T4→T1, one step per clock. The instruction-cycle boundary is the clock edge that ends T4.
- R2: The program counter and the execute-stage outputs change only at an instruction-cycle boundary. `imem_addr` equals the program counter for the whole instruction cycle.
- R3: With no other event at a boundary, the counter steps by one, wrapping from 0x7FF to 0x000. The word fetched at the old counter value moves to execute with `ex_pc` equal to its address and `ex_nop` = 0.
- R4: Reset sets the counter to 0x000 and `ex_nop` to 1, with `push_en` = 0 and `irq_ack` = 0. Reset is applied asynchronously and released after two clock edges.
- R5: A live `ctl_jump`, `ctl_call` or `ctl_ret` loads `ctl_target` into the counter, and the next instruction cycle is a dummy.
- R6: A live `ctl_call` raises `push_en` during T4 with `push_addr` = `ex_pc` + 1. A jump or return pushes nothing.
- R7: A live `ctl_skip` advances the counter by one and makes the next instruction cycle a dummy. Without `ctl_skip` the flow is sequential.
- R8: A live write (`dwr_en`) to data address 0x06 replaces counter bits [7:0] with `dwr_data` and keeps bits [10:8]. The next cycle is a dummy. This write outranks a skip. Writes to any other address leave the flow unchanged.
- R9: When `drd_addr` is 0x06, `drd_hit` = 1 and `drd_pcl` = counter bits [7:0]. For any other address both outputs are 0.
- R10: During a dummy cycle (`ex_nop` = 1), `ctl_jump`, `ctl_call`, `ctl_ret`, `ctl_skip` and data writes have no effect.
- R11: If `irq_ext` or `irq_int` is high at a boundary and no jump, call or return is live, the request is taken. The counter loads 0x004 for external or 0x008 for internal, with external winning. During T4, `irq_ack` is one-hot (bit0 external, bit1 internal) and `push_en` = 1. `push_addr` is the next address that would otherwise have executed: the page-write target, the counter + 1 after a taken skip, or the counter itself. The next cycle is a dummy.
- R12: When a jump, call or return is live, interrupt requests wait for a later boundary, and the transfer takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase | output | 4 | One-hot instruction phase, bit0 = T1 |
| imem_addr | output | 11 | Program memory fetch address |
| imem_rdata | input | 14 | Synchronous program memory read data |
| ex_insn | output | 14 | Word in the execute stage |
| ex_pc | output | 11 | Address of the word in the execute stage |
| ex_nop | output | 1 | Dummy cycle; execute stage must not write |
| ctl_jump | input | 1 | Executing instruction is a jump |
| ctl_call | input | 1 | Executing instruction is a call |
| ctl_ret | input | 1 | Executing instruction is a return |
| ctl_target | input | 11 | Destination for jump/call/return |
| ctl_skip | input | 1 | Skip condition is true |
| dwr_en | input | 1 | Data bus write strobe |
| dwr_addr | input | 7 | Data bus write address |
| dwr_data | input | 8 | Data bus write data |
| drd_addr | input | 7 | Data bus read address |
| drd_hit | output | 1 | Read address selects the low counter byte |
| drd_pcl | output | 8 | Low counter byte read data |
| irq_ext | input | 1 | External interrupt request |
| irq_int | input | 1 | Internal interrupt request |
| irq_ack | output | 2 | Interrupt taken (bit0 external, bit1 internal), T4 only |
| push_en | output | 1 | Push return address onto the stack, T4 only |
| push_addr | output | 11 | Return address to push |

## Verification
The critical overlap is an interrupt arriving in the same instruction cycle as a taken skip or a low-byte write. The pushed return address must then follow the lower-priority event, and a live jump, call or return must defer the request entirely. Directed cycles drive each such pair at once. Random cycles also let requests coincide with every other control input. A bench model, built from the priority order, predicts `irq_ack`, `push_addr`, the next fetch address and the dummy flag, and these are compared during T4 and in the following cycle.

// File: rtl/pcf_pkg.sv
package pcf_pkg;
  // Which source supplied the next program counter value at a boundary.
  typedef enum logic [2:0] {
    NS_INC  = 3'd0,
    NS_SKIP = 3'd1,
    NS_PCL  = 3'd2,
    NS_XFER = 3'd3,
    NS_IRQ  = 3'd4
  } nsel_e;
endpackage

// File: rtl/pcf_phase_gen.sv
module pcf_phase_gen #(
  parameter int PHASES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PHASES-1:0] phase,
  output logic              last
);
  localparam logic [PHASES-1:0] PH_INIT = PHASES'(1);

  logic [PHASES-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = {ph_q[PHASES-2:0], ph_q[PHASES-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_INIT;
    else        ph_q <= ph_d;
  end

  assign phase = ph_q;
  assign last  = ph_q[PHASES-1];

  // R1: exactly one phase active
  a_r1_phase_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ph_q) == 1);
  // R1: last phase is followed by the first
  a_r1_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q[PHASES-1] |=> ph_q[0]);
endmodule

// File: rtl/pcf_pc_next.sv
module pcf_pc_next
  import pcf_pkg::*;
#(
  parameter int              PC_W    = 11,
  parameter int              PG_W    = 8,
  parameter logic [PC_W-1:0] VEC_EXT = 11'h004,
  parameter logic [PC_W-1:0] VEC_INT = 11'h008
) (
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] ex_pc,
  input  logic            ex_live,
  input  logic            ctl_jump,
  input  logic            ctl_call,
  input  logic            ctl_ret,
  input  logic [PC_W-1:0] ctl_target,
  input  logic            ctl_skip,
  input  logic            pcl_wr,
  input  logic [PG_W-1:0] pcl_data,
  input  logic            irq_ext,
  input  logic            irq_int,
  output logic [PC_W-1:0] pc_nxt,
  output logic            flush,
  output nsel_e           sel,
  output logic            push_req,
  output logic [PC_W-1:0] push_addr,
  output logic [1:0]      ack
);
  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  logic            xfer, pclw, skp, irq;
  logic [PC_W-1:0] pc_inc, ex_inc, pcl_tgt, resume;

  always_comb begin
    xfer    = ex_live & (ctl_jump | ctl_call | ctl_ret);
    pclw    = ex_live & pcl_wr;
    skp     = ex_live & ctl_skip;
    irq     = (irq_ext | irq_int) & ~xfer;
    pc_inc  = pc + ONE;
    ex_inc  = ex_pc + ONE;
    pcl_tgt = {pc[PC_W-1:PG_W], pcl_data};
    resume  = pclw ? pcl_tgt : (skp ? pc_inc : pc);

    sel       = NS_INC;
    pc_nxt    = pc_inc;
    flush     = 1'b0;
    push_req  = 1'b0;
    push_addr = ex_inc;
    ack       = 2'b00;

    if (irq) begin
      sel       = NS_IRQ;
      pc_nxt    = irq_ext ? VEC_EXT : VEC_INT;
      flush     = 1'b1;
      push_req  = 1'b1;
      push_addr = resume;
      ack       = irq_ext ? 2'b01 : 2'b10;
    end else if (xfer) begin
      sel      = NS_XFER;
      pc_nxt   = ctl_target;
      flush    = 1'b1;
      push_req = ctl_call;
    end else if (pclw) begin
      sel    = NS_PCL;
      pc_nxt = pcl_tgt;
      flush  = 1'b1;
    end else if (skp) begin
      sel   = NS_SKIP;
      flush = 1'b1;
    end
  end
endmodule

// File: rtl/pcf_exec_stage.sv
module pcf_exec_stage #(
  parameter int PC_W   = 11,
  parameter int INSN_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              flush,
  input  logic [INSN_W-1:0] fetch_word,
  input  logic [PC_W-1:0]   fetch_pc,
  output logic [INSN_W-1:0] ex_insn,
  output logic [PC_W-1:0]   ex_pc,
  output logic              ex_nop
);
  logic [INSN_W-1:0] insn_q, insn_d;
  logic [PC_W-1:0]   epc_q, epc_d;
  logic              vld_q, vld_d;

  always_comb begin
    insn_d = insn_q;
    epc_d  = epc_q;
    vld_d  = vld_q;
    if (load) begin
      insn_d = fetch_word;
      epc_d  = fetch_pc;
      vld_d  = ~flush;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      insn_q <= '0;
      epc_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      insn_q <= insn_d;
      epc_q  <= epc_d;
      vld_q  <= vld_d;
    end
  end

  assign ex_insn = insn_q;
  assign ex_pc   = epc_q;
  assign ex_nop  = ~vld_q;

  // R5: a flushed boundary yields a dummy cycle
  a_r5_flush_dummy: assert property (@(posedge clk) disable iff (!rst_n)
    (load && flush) |=> ex_nop);
  // R3: an unflushed boundary yields a live instruction
  a_r3_load_live: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !flush) |=> !ex_nop);
  // R2: execute stage holds between boundaries
  a_r2_ex_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(epc_q) && $stable(vld_q)));
endmodule

// File: rtl/pc_fetch_seq.sv
module pc_fetch_seq
  import pcf_pkg::*;
#(
  parameter int              PC_W     = 11,
  parameter int              INSN_W   = 14,
  parameter int              DA_W     = 7,
  parameter int              PHASES   = 4,
  parameter logic [DA_W-1:0] PCL_ADDR = 7'h06,
  parameter logic [PC_W-1:0] VEC_EXT  = 11'h004,
  parameter logic [PC_W-1:0] VEC_INT  = 11'h008
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PHASES-1:0] phase,
  output logic [PC_W-1:0]   imem_addr,
  input  logic [INSN_W-1:0] imem_rdata,
  output logic [INSN_W-1:0] ex_insn,
  output logic [PC_W-1:0]   ex_pc,
  output logic              ex_nop,
  input  logic              ctl_jump,
  input  logic              ctl_call,
  input  logic              ctl_ret,
  input  logic [PC_W-1:0]   ctl_target,
  input  logic              ctl_skip,
  input  logic              dwr_en,
  input  logic [DA_W-1:0]   dwr_addr,
  input  logic [7:0]        dwr_data,
  input  logic [DA_W-1:0]   drd_addr,
  output logic              drd_hit,
  output logic [7:0]        drd_pcl,
  input  logic              irq_ext,
  input  logic              irq_int,
  output logic [1:0]        irq_ack,
  output logic              push_en,
  output logic [PC_W-1:0]   push_addr
);
  localparam int PG_W = 8;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  logic cyc_end;

  pcf_phase_gen #(.PHASES(PHASES)) u_phase (
    .clk   (clk),
    .rst_n (rst_i_n),
    .phase (phase),
    .last  (cyc_end)
  );

  logic [PC_W-1:0] pc_q, pc_d, pc_nxt, push_a;
  logic            flush, push_req, pcl_wr;
  logic [1:0]      ack;
  nsel_e           sel;

  assign pcl_wr = dwr_en & (dwr_addr == PCL_ADDR);

  pcf_pc_next #(
    .PC_W    (PC_W),
    .PG_W    (PG_W),
    .VEC_EXT (VEC_EXT),
    .VEC_INT (VEC_INT)
  ) u_next (
    .pc         (pc_q),
    .ex_pc      (ex_pc),
    .ex_live    (~ex_nop),
    .ctl_jump   (ctl_jump),
    .ctl_call   (ctl_call),
    .ctl_ret    (ctl_ret),
    .ctl_target (ctl_target),
    .ctl_skip   (ctl_skip),
    .pcl_wr     (pcl_wr),
    .pcl_data   (dwr_data),
    .irq_ext    (irq_ext),
    .irq_int    (irq_int),
    .pc_nxt     (pc_nxt),
    .flush      (flush),
    .sel        (sel),
    .push_req   (push_req),
    .push_addr  (push_a),
    .ack        (ack)
  );

  always_comb begin
    pc_d = pc_q;
    if (cyc_end) pc_d = pc_nxt;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) pc_q <= '0;
    else          pc_q <= pc_d;
  end

  pcf_exec_stage #(.PC_W(PC_W), .INSN_W(INSN_W)) u_exec (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .load       (cyc_end),
    .flush      (flush),
    .fetch_word (imem_rdata),
    .fetch_pc   (pc_q),
    .ex_insn    (ex_insn),
    .ex_pc      (ex_pc),
    .ex_nop     (ex_nop)
  );

  assign imem_addr = pc_q;
  assign push_en   = cyc_end & push_req;
  assign push_addr = push_a;
  assign irq_ack   = cyc_end ? ack : 2'b00;
  assign drd_hit   = (drd_addr == PCL_ADDR);
  assign drd_pcl   = drd_hit ? pc_q[PG_W-1:0] : 8'h00;

  // R2: counter holds between boundaries
  a_r2_pc_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    !cyc_end |=> $stable(pc_q));
  // R8: a page write keeps the upper counter bits
  a_r8_pcl_page: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cyc_end && sel == NS_PCL) |=> (pc_q[PC_W-1:PG_W] == $past(pc_q[PC_W-1:PG_W])));
  // R11: an acknowledged interrupt always pushes, with a one-hot ack
  a_r11_ack_push: assert property (@(posedge clk) disable iff (!rst_i_n)
    (irq_ack != 2'b00) |-> (push_en && $countones(irq_ack) == 1));
  // R12: a live transfer blocks interrupt acceptance
  a_r12_defer: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cyc_end && !ex_nop && (ctl_jump || ctl_call || ctl_ret)) |-> (irq_ack == 2'b00));
  // R10: in a dummy cycle only an interrupt may push
  a_r10_dummy_quiet: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ex_nop && push_en) |-> (irq_ack != 2'b00));
  // R4: nothing is pushed or acknowledged outside T4
  a_r4_t4_only: assert property (@(posedge clk) disable iff (!rst_i_n)
    !cyc_end |-> (!push_en && irq_ack == 2'b00));
endmodule

// File: tb/pc_fetch_seq_tb.sv
module pc_fetch_seq_tb;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  phase;
  logic [10:0] imem_addr;
  logic [13:0] imem_rdata;
  logic [13:0] ex_insn;
  logic [10:0] ex_pc;
  logic        ex_nop;
  logic        ctl_jump, ctl_call, ctl_ret, ctl_skip;
  logic [10:0] ctl_target;
  logic        dwr_en;
  logic [6:0]  dwr_addr;
  logic [7:0]  dwr_data;
  logic [6:0]  drd_addr;
  logic        drd_hit;
  logic [7:0]  drd_pcl;
  logic        irq_ext, irq_int;
  logic [1:0]  irq_ack;
  logic        push_en;
  logic [10:0] push_addr;

  always #2.5 clk = ~clk;

  pc_fetch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .phase(phase), .imem_addr(imem_addr),
    .imem_rdata(imem_rdata), .ex_insn(ex_insn), .ex_pc(ex_pc), .ex_nop(ex_nop),
    .ctl_jump(ctl_jump), .ctl_call(ctl_call), .ctl_ret(ctl_ret),
    .ctl_target(ctl_target), .ctl_skip(ctl_skip), .dwr_en(dwr_en),
    .dwr_addr(dwr_addr), .dwr_data(dwr_data), .drd_addr(drd_addr),
    .drd_hit(drd_hit), .drd_pcl(drd_pcl), .irq_ext(irq_ext), .irq_int(irq_int),
    .irq_ack(irq_ack), .push_en(push_en), .push_addr(push_addr)
  );

  function automatic logic [13:0] rom_f(logic [10:0] a);
    return {a[2:0], a} ^ 14'h2A5;
  endfunction

  always_ff @(posedge clk) imem_rdata <= rom_f(imem_addr);

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench reference state
  logic [10:0] m_pc, m_expc;
  bit          m_valid;
  string       m_why;

  task automatic cycle(bit j, bit c, bit r, bit s, logic [10:0] tgt,
                       bit w, logic [6:0] wa, logic [7:0] wd,
                       bit ie, bit ii, logic [6:0] ra);
    bit          live, xfer, pclw, sk, irq, push;
    logic [1:0]  ack;
    logic [10:0] hold, npc, paddr;
    string       tg;
    ctl_jump = j; ctl_call = c; ctl_ret = r; ctl_skip = s; ctl_target = tgt;
    dwr_en = w; dwr_addr = wa; dwr_data = wd; irq_ext = ie; irq_int = ii;
    drd_addr = ra;
    #0.5;
    check("R1 phase T1", 32'(phase), 32'h1);
    check("R2 fetch address", 32'(imem_addr), 32'(m_pc));
    check({m_why, " dummy flag"}, 32'(ex_nop), 32'(!m_valid));
    if (m_valid) begin
      check("R3 ex_pc", 32'(ex_pc), 32'(m_expc));
      check("R3 ex_insn", 32'(ex_insn), 32'(rom_f(m_expc)));
    end
    check("R9 read hit", 32'(drd_hit), 32'(ra == 7'h06));
    check("R9 read data", 32'(drd_pcl), (ra == 7'h06) ? 32'(m_pc[7:0]) : 32'h0);

    live = m_valid;
    xfer = live && (j || c || r);
    pclw = live && w && (wa == 7'h06);
    sk   = live && s;
    irq  = (ie || ii) && !xfer;
    hold = pclw ? {m_pc[10:8], wd} : (sk ? m_pc + 11'd1 : m_pc);
    ack  = irq ? (ie ? 2'b01 : 2'b10) : 2'b00;
    push = irq || (xfer && c);
    paddr = irq ? hold : m_expc + 11'd1;
    npc  = irq ? (ie ? 11'h004 : 11'h008) :
           xfer ? tgt : pclw ? {m_pc[10:8], wd} : m_pc + 11'd1;

    @(negedge clk);
    check("R1 phase T2", 32'(phase), 32'h2);
    check("R2 fetch address held", 32'(imem_addr), 32'(m_pc));
    @(negedge clk);
    check("R1 phase T3", 32'(phase), 32'h4);
    @(negedge clk);
    check("R1 phase T4", 32'(phase), 32'h8);
    tg = ((ie || ii) && xfer) ? "R12" : "R11";
    check({tg, " irq_ack"}, 32'(irq_ack), 32'(ack));
    tg = irq ? "R11" : (!live && c) ? "R10" : "R6";
    check({tg, " push_en"}, 32'(push_en), 32'(push));
    if (push) check({tg, " push_addr"}, 32'(push_addr), 32'(paddr));

    if (irq)       m_why = "R11";
    else if (xfer) m_why = "R5";
    else if (pclw) m_why = "R8";
    else if (sk)   m_why = "R7";
    else if (!live && (j || c || r || s || w)) m_why = "R10";
    else           m_why = "R3";
    m_valid = !(irq || xfer || pclw || sk);
    m_expc  = m_pc;
    m_pc    = npc;
    @(negedge clk);
  endtask

  task automatic idle();
    cycle(0, 0, 0, 0, 11'h0, 0, 7'h0, 8'h0, 0, 0, 7'h06);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1207));
    ctl_jump = 0; ctl_call = 0; ctl_ret = 0; ctl_skip = 0; ctl_target = '0;
    dwr_en = 0; dwr_addr = '0; dwr_data = '0; drd_addr = '0;
    irq_ext = 0; irq_int = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R4: reset state
    check("R4 dummy after reset", 32'(ex_nop), 32'h1);
    check("R4 counter zero", 32'(imem_addr), 32'h0);
    check("R4 no push", 32'(push_en), 32'h0);
    check("R4 no ack", 32'(irq_ack), 32'h0);
    check("R1 reset phase", 32'(phase), 32'h1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    m_pc = '0; m_expc = '0; m_valid = 1'b0; m_why = "R4";

    // sequential start and controls ignored in the first dummy (R10)
    cycle(1, 1, 0, 1, 11'h155, 1, 7'h06, 8'h33, 0, 0, 7'h06);
    idle(); idle();
    // R5 jump near the top, then R3 wrap to 0x000
    cycle(1, 0, 0, 0, 11'h7FE, 0, 7'h0, 8'h0, 0, 0, 7'h01);
    idle(); idle(); idle(); idle();
    // R6 call, R5 return
    cycle(0, 1, 0, 0, 11'h3F0, 0, 7'h0, 8'h0, 0, 0, 7'h06);
    idle(); idle();
    cycle(0, 0, 1, 0, 11'h123, 0, 7'h0, 8'h0, 0, 0, 7'h06);
    idle(); idle();
    // R8 page write, then write elsewhere ignored
    cycle(0, 0, 0, 0, 11'h0, 1, 7'h06, 8'hFE, 0, 0, 7'h06);
    idle(); idle(); idle();
    cycle(0, 0, 0, 0, 11'h0, 1, 7'h07, 8'h10, 0, 0, 7'h06);
    idle();
    // R8 write beats skip
    cycle(0, 0, 0, 1, 11'h0, 1, 7'h06, 8'h40, 0, 0, 7'h06);
    idle(); idle();
    // R7 skip, and false skip
    cycle(0, 0, 0, 1, 11'h0, 0, 7'h0, 8'h0, 0, 0, 7'h06);
    idle(); idle();
    // R11 interrupt coinciding with skip
    cycle(0, 0, 0, 1, 11'h0, 0, 7'h0, 8'h0, 0, 1, 7'h06);
    idle(); idle();
    // R11 interrupt coinciding with page write
    cycle(0, 0, 0, 0, 11'h0, 1, 7'h06, 8'h80, 1, 0, 7'h06);
    idle(); idle();
    // R11 both requests, external wins
    cycle(0, 0, 0, 0, 11'h0, 0, 7'h0, 8'h0, 1, 1, 7'h06);
    idle(); idle();
    // R12 call with pending interrupt: deferred, taken in the dummy after
    cycle(0, 1, 0, 0, 11'h600, 0, 7'h0, 8'h0, 1, 0, 7'h06);
    cycle(0, 0, 0, 0, 11'h0, 0, 7'h0, 8'h0, 1, 0, 7'h06);
    idle(); idle();

    for (int n = 0; n < 400; n++) begin
      int k;
      bit j, c, r, s, w, ie, ii;
      logic [6:0] wa;
      k = $urandom_range(0, 15);
      j = (k <= 1); c = (k == 2); r = (k == 3);
      s = (k == 4) || (k == 5) || ((k >= 8) && (k <= 10) && $urandom_range(0, 1) == 1);
      w = (k == 6) || (k == 7);
      wa = (k == 6) ? 7'h06 : 7'($urandom_range(7, 127));
      ie = (k == 8) || (k == 10) || (k == 11 && $urandom_range(0, 1) == 1);
      ii = (k == 9) || (k == 10);
      cycle(j, c, r, s, 11'($urandom_range(0, 2047)), w, wa,
            8'($urandom_range(0, 255)), ie, ii,
            ($urandom_range(0, 1) == 1) ? 7'h06 : 7'($urandom_range(0, 5)));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule